// File: doc/BRIEF.md
# Board System Control Register Bank

This block is a bank of board-level system registers on a simple 32-bit bus that has a valid strobe and a write strobe. Software reads the board's identity, the processor identity words of the two daughterboard sites, the switch bank, the card-detect and write-protect pins and the master-site strap. It drives the user LEDs and the flash write-protect control, and it reads two free-running tick counters.

Two flag words give software a small scratch area. Each flag word has a set address and a clear address. A write to the set address ORs the data into the word. A write to the clear address clears every bit that is 1 in the data. A read of the set address returns the word. The volatile flag word is cleared by any reset. The persistent flag word keeps its value through a soft reset and is cleared only by the power-on reset.

Bus handling is one small state machine. In `ST_IDLE` the bank waits. A read strobe moves it to `ST_RESP` (transition *read_accept*), where the registered read data is presented with `rd_valid` high. A further read strobe keeps it in `ST_RESP` (*read_again*). Any other cycle returns it to `ST_IDLE` (*resp_done*). Writes take effect at the clock edge of the strobe and never leave `ST_IDLE`.

Top module: `sysctl_regbank`

## Requirements
- R1: While `rst_n` or `por_n` is low, and right after either is released, `rd_data` reads 0, `rd_valid` is 0, `led_out` is 0 and `flash_wp_n` is 0.
- R2: A read strobe (`bus_valid`=1, `bus_write`=0) in cycle N gives `rd_valid`=1 and the addressed value on `rd_data` after edge N. A cycle with no read strobe gives `rd_valid`=0 after its edge, and a write strobe never raises `rd_valid`.
- R3: Offset 0x000 reads the parameter `BOARD_CODE` in bits 27:16, with every other bit 0. Offsets 0x084 and 0x088 read the pins `procid0_in` and `procid1_in` unchanged.
- R4: Offset 0x008 is a read/write LED register. Bit n (n = 0 to 7) drives `led_out[n]`, and bits 31:8 read 0. A write to any other offset leaves `led_out` unchanged.
- R5: Offset 0x004 reads `switch_in` in bits 7:0, with every other bit 0.
- R6: Offset 0x048 reads `card_in` in bit 0 and `wprot_in` in bit 1. Offset 0x04C is a read/write register whose bit 0 drives the active-low flash write-protect output `flash_wp_n`.
- R7: Offset 0x060 reads `site_sel_in` in bit 14, where 0 selects site 1 and 1 selects site 2. A write to it has no effect.
- R8: Volatile flags: a write to 0x030 ORs the write data into the flags, a write to 0x034 clears every flag bit that is 1 in the write data, a read of 0x030 returns the flags, and a read of 0x034 returns 0.
- R9: Persistent flags follow the same rules as R8, with 0x038 for set and read and 0x03C for clear.
- R10: A low pulse on `rst_n` clears the volatile flags and leaves the persistent flags unchanged. A low pulse on `por_n` clears both flag words.
- R11: The counters at 0x024 (`tick_slow`) and 0x05C (`tick_fast`) each add 1 on every clock where their tick input is 1, and wrap from all ones to 0 at width `CNT_W`. Writes to them have no effect.
- R12: A read of an unmapped offset returns 0. A write to an unmapped offset changes no readable register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | `rd_data` holds the result of the previous cycle's read |
| switch_in | input | 8 | Board switch pins |
| card_in | input | 1 | Card inserted |
| wprot_in | input | 1 | Card write protected |
| site_sel_in | input | 1 | Master-site strap |
| procid0_in | input | 32 | Processor identity, site 1 |
| procid1_in | input | 32 | Processor identity, site 2 |
| tick_slow | input | 1 | Slow-counter increment enable |
| tick_fast | input | 1 | Fast-counter increment enable |
| led_out | output | 8 | LED drive |
| flash_wp_n | output | 1 | Flash write protect, active low |

## Verification
If the bus state machine holds a wrong state, `rd_valid` shows it at the first edge after the strobe. A missed or lingering response is therefore visible within one cycle. A wrong flag or counter value stays hidden until the next read of that offset, which reports it one cycle after the strobe. The bench therefore reads back every register right after each write and after each reset pulse. A flag word in the wrong reset domain shows up only across a reset pulse, so each reset is pulsed on its own with both flag words already set.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_IDENT    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SWITCH   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_LED      = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SLOWCNT  = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_VF_SET   = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_VF_CLR   = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_PF_SET   = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_PF_CLR   = 12'h03C;
    localparam logic [ADDR_W-1:0] OFS_CARD     = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_FLASHCTL = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_FASTCNT  = 12'h05C;
    localparam logic [ADDR_W-1:0] OFS_MISC     = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_PROC0    = 12'h084;
    localparam logic [ADDR_W-1:0] OFS_PROC1    = 12'h088;

    localparam int unsigned IDENT_CODE_LSB = 16;
    localparam int unsigned MISC_SITE_BIT  = 14;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/sysctl_flagword.sv
module sysctl_flagword #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    logic [W-1:0] value_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            value_q <= '0;
        end else if (set_en) begin
            value_q <= value_q | wdata;
        end else if (clr_en) begin
            value_q <= value_q & ~wdata;
        end
    end

    assign value = value_q;
endmodule

// File: rtl/sysctl_tickctr.sv
module sysctl_tickctr #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         tick,
    output logic [W-1:0] count
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned LED_N      = 8,
    parameter int unsigned SW_N       = 8,
    parameter int unsigned CNT_W      = 32,
    parameter logic [11:0] BOARD_CODE = 12'h190
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  por_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    input  logic [SW_N-1:0]       switch_in,
    input  logic                  card_in,
    input  logic                  wprot_in,
    input  logic                  site_sel_in,
    input  logic [DATA_W-1:0]     procid0_in,
    input  logic [DATA_W-1:0]     procid1_in,
    input  logic                  tick_slow,
    input  logic                  tick_fast,
    output logic [LED_N-1:0]      led_out,
    output logic                  flash_wp_n
);
    localparam int unsigned CODE_W = 12;

    // Soft reset domain: any reset
    logic rst_any_n;
    assign rst_any_n = rst_n & por_n;

    logic wr_stb, rd_stb;
    assign wr_stb = bus_valid & bus_write;
    assign rd_stb = bus_valid & ~bus_write;

    // Write decode
    logic we_led, we_flash, we_vf_set, we_vf_clr, we_pf_set, we_pf_clr;
    assign we_led    = wr_stb && (bus_addr == OFS_LED);
    assign we_flash  = wr_stb && (bus_addr == OFS_FLASHCTL);
    assign we_vf_set = wr_stb && (bus_addr == OFS_VF_SET);
    assign we_vf_clr = wr_stb && (bus_addr == OFS_VF_CLR);
    assign we_pf_set = wr_stb && (bus_addr == OFS_PF_SET);
    assign we_pf_clr = wr_stb && (bus_addr == OFS_PF_CLR);

    // LED and flash control storage
    logic [LED_N-1:0] led_q;
    logic             flash_q;

    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            led_q   <= '0;
            flash_q <= 1'b0;
        end else begin
            if (we_led)   led_q   <= bus_wdata[LED_N-1:0];
            if (we_flash) flash_q <= bus_wdata[0];
        end
    end

    assign led_out    = led_q;
    assign flash_wp_n = flash_q;

    // Flag words: volatile in the soft domain, persistent in the power-on domain
    logic [DATA_W-1:0] vflag_q, pflag_q;

    sysctl_flagword #(.W(DATA_W)) u_vflag (
        .clk    (clk),
        .arst_n (rst_any_n),
        .set_en (we_vf_set),
        .clr_en (we_vf_clr),
        .wdata  (bus_wdata),
        .value  (vflag_q)
    );

    sysctl_flagword #(.W(DATA_W)) u_pflag (
        .clk    (clk),
        .arst_n (por_n),
        .set_en (we_pf_set),
        .clr_en (we_pf_clr),
        .wdata  (bus_wdata),
        .value  (pflag_q)
    );

    // Free-running counters
    logic [CNT_W-1:0] slow_cnt_q, fast_cnt_q;

    sysctl_tickctr #(.W(CNT_W)) u_slowcnt (
        .clk    (clk),
        .arst_n (rst_any_n),
        .tick   (tick_slow),
        .count  (slow_cnt_q)
    );

    sysctl_tickctr #(.W(CNT_W)) u_fastcnt (
        .clk    (clk),
        .arst_n (rst_any_n),
        .tick   (tick_fast),
        .count  (fast_cnt_q)
    );

    // Read multiplexer
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_IDENT:    rd_mux[IDENT_CODE_LSB +: CODE_W] = BOARD_CODE;
            OFS_SWITCH:   rd_mux[SW_N-1:0]  = switch_in;
            OFS_LED:      rd_mux[LED_N-1:0] = led_q;
            OFS_SLOWCNT:  rd_mux[CNT_W-1:0] = slow_cnt_q;
            OFS_VF_SET:   rd_mux = vflag_q;
            OFS_PF_SET:   rd_mux = pflag_q;
            OFS_CARD:     rd_mux[1:0] = {wprot_in, card_in};
            OFS_FLASHCTL: rd_mux[0] = flash_q;
            OFS_FASTCNT:  rd_mux[CNT_W-1:0] = fast_cnt_q;
            OFS_MISC:     rd_mux[MISC_SITE_BIT] = site_sel_in;
            OFS_PROC0:    rd_mux = procid0_in;
            OFS_PROC1:    rd_mux = procid1_in;
            default:      rd_mux = '0;
        endcase
    end

    // Bus response state machine
    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_stb) state_d = ST_RESP;   // read_accept
            ST_RESP: begin
                if (rd_stb) state_d = ST_RESP;        // read_again
                else        state_d = ST_IDLE;        // resp_done
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // Output process
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            rdata_q <= '0;
        end else if (rd_stb) begin
            rdata_q <= rd_mux;
        end
    end

    assign rd_data  = rdata_q;
    assign rd_valid = (state_q == ST_RESP);
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned LED_N = 8,
    parameter int unsigned CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [LED_N-1:0]  led_out,
    input logic [DATA_W-1:0] vflag,
    input logic [DATA_W-1:0] pflag,
    input logic              tick_slow,
    input logic [CNT_W-1:0]  slow_cnt
);
    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return a inside {OFS_IDENT, OFS_SWITCH, OFS_LED, OFS_SLOWCNT,
                         OFS_VF_SET, OFS_VF_CLR, OFS_PF_SET, OFS_PF_CLR,
                         OFS_CARD, OFS_FLASHCTL, OFS_FASTCNT, OFS_MISC,
                         OFS_PROC0, OFS_PROC1};
    endfunction

    logic rd_req, wr_req;
    assign rd_req = bus_valid && !bus_write;
    assign wr_req = bus_valid && bus_write;

    assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rd_req |=> rd_valid);

    assert_no_resp_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !rd_req |=> !rd_valid);

    assert_led_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(wr_req && bus_addr == OFS_LED) |=> $stable(led_out));

    assert_vflag_set_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_req && bus_addr == OFS_VF_SET) |=> ((vflag & $past(bus_wdata)) == $past(bus_wdata)));

    assert_vflag_clr_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_req && bus_addr == OFS_VF_CLR) |=> ((vflag & $past(bus_wdata)) == '0));

    assert_pflag_set_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_req && bus_addr == OFS_PF_SET) |=> ((pflag & $past(bus_wdata)) == $past(bus_wdata)));

    assert_pflag_clr_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_req && bus_addr == OFS_PF_CLR) |=> ((pflag & $past(bus_wdata)) == '0));

    assert_cnt_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (tick_slow && (&slow_cnt)) |=> (slow_cnt == '0));

    assert_cnt_idle_R11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !tick_slow |=> $stable(slow_cnt));

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (rd_req && !is_mapped(bus_addr)) |=> (rd_data == '0));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.LED_N(LED_N), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .led_out   (led_out),
    .vflag     (vflag_q),
    .pflag     (pflag_q),
    .tick_slow (tick_slow),
    .slow_cnt  (slow_cnt_q)
);

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/1ps
module sim_sysctl_regbank;
    localparam int unsigned CNT_W = 8;
    localparam logic [11:0] CODE = 12'h190;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [7:0]  switch_in = 8'hA5;
    logic        card_in = 1'b1;
    logic        wprot_in = 1'b0;
    logic        site_sel_in = 1'b1;
    logic [31:0] procid0_in = 32'h1400_0225;
    logic [31:0] procid1_in = 32'h0C00_0191;
    logic        tick_slow = 1'b0;
    logic        tick_fast = 1'b0;
    logic [7:0]  led_out;
    logic        flash_wp_n;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    sysctl_regbank #(.CNT_W(CNT_W), .BOARD_CODE(CODE)) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .switch_in(switch_in), .card_in(card_in), .wprot_in(wprot_in),
        .site_sel_in(site_sel_in), .procid0_in(procid0_in), .procid1_in(procid1_in),
        .tick_slow(tick_slow), .tick_fast(tick_fast),
        .led_out(led_out), .flash_wp_n(flash_wp_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(req, d, exp);
    endtask

    task automatic pulse(input bit fast, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
            @(negedge clk);
            tick_fast = 1'b0; tick_slow = 1'b0;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        check("R1 led_out", {24'h0, led_out}, 32'h0);
        check("R1 flash_wp_n", {31'h0, flash_wp_n}, 32'h0);
    endtask

    task automatic t_latency;
        logic [31:0] d;
        bus_rd(12'h004, d);
        check("R2 rd_valid after read", {31'h0, rd_valid}, 32'h1);
        check("R2 data after read", d, 32'h0000_00A5);
        @(negedge clk);
        check("R2 rd_valid idle", {31'h0, rd_valid}, 32'h0);
        bus_wr(12'h070, 32'h1);
        check("R2 rd_valid after write", {31'h0, rd_valid}, 32'h0);
        // back-to-back reads
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h084;
        @(negedge clk);
        check("R2 first of pair", rd_data, 32'h1400_0225);
        bus_addr = 12'h088;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R2 second of pair", rd_data, 32'h0C00_0191);
        check("R2 rd_valid pair", {31'h0, rd_valid}, 32'h1);
    endtask

    task automatic t_ident;
        rd_check("R3 ident", 12'h000, {4'h0, CODE, 16'h0});
        rd_check("R3 procid0", 12'h084, 32'h1400_0225);
        procid1_in = 32'hFFFF_F00D;
        rd_check("R3 procid1", 12'h088, 32'hFFFF_F00D);
    endtask

    task automatic t_led;
        bus_wr(12'h008, 32'hFFFF_FF5A);
        check("R4 led_out", {24'h0, led_out}, 32'h5A);
        rd_check("R4 led readback", 12'h008, 32'h0000_005A);
        bus_wr(12'h008, 32'h0000_005B);
        check("R4 led bit0", {24'h0, led_out}, 32'h5B);
        bus_wr(12'h00C, 32'h0000_00FF);
        check("R4 led other offset", {24'h0, led_out}, 32'h5B);
    endtask

    task automatic t_switch;
        switch_in = 8'h3C;
        rd_check("R5 switches", 12'h004, 32'h0000_003C);
    endtask

    task automatic t_card_flash;
        card_in = 1'b0; wprot_in = 1'b1;
        rd_check("R6 card status", 12'h048, 32'h0000_0002);
        card_in = 1'b1;
        rd_check("R6 card status both", 12'h048, 32'h0000_0003);
        bus_wr(12'h04C, 32'h0000_0001);
        check("R6 flash_wp_n high", {31'h0, flash_wp_n}, 32'h1);
        rd_check("R6 flash readback", 12'h04C, 32'h0000_0001);
        bus_wr(12'h04C, 32'h0000_0000);
        check("R6 flash_wp_n low", {31'h0, flash_wp_n}, 32'h0);
    endtask

    task automatic t_misc;
        rd_check("R7 site 2", 12'h060, 32'h0000_4000);
        site_sel_in = 1'b0;
        bus_wr(12'h060, 32'hFFFF_FFFF);
        rd_check("R7 site 1 write ignored", 12'h060, 32'h0000_0000);
    endtask

    task automatic t_vflags;
        bus_wr(12'h030, 32'h0000_00F0);
        bus_wr(12'h030, 32'h8000_000F);
        rd_check("R8 set OR", 12'h030, 32'h8000_00FF);
        bus_wr(12'h034, 32'h8000_0081);
        rd_check("R8 clear", 12'h030, 32'h0000_007E);
        rd_check("R8 clear addr reads 0", 12'h034, 32'h0);
        rd_check("R8 pflag untouched", 12'h038, 32'h0);
    endtask

    task automatic t_pflags;
        bus_wr(12'h038, 32'h1234_0000);
        bus_wr(12'h038, 32'h0000_5678);
        rd_check("R9 set OR", 12'h038, 32'h1234_5678);
        bus_wr(12'h03C, 32'h0004_0008);
        rd_check("R9 clear", 12'h038, 32'h1230_5670);
        rd_check("R9 clear addr reads 0", 12'h03C, 32'h0);
    endtask

    task automatic t_reset_domains;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_check("R10 vflag after soft", 12'h030, 32'h0);
        rd_check("R10 pflag after soft", 12'h038, 32'h1230_5670);
        check("R1 led after soft", {24'h0, led_out}, 32'h0);
        bus_wr(12'h030, 32'h0000_0011);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd_check("R10 vflag after por", 12'h030, 32'h0);
        rd_check("R10 pflag after por", 12'h038, 32'h0);
    endtask

    task automatic t_counters;
        pulse(1'b0, 3);
        rd_check("R11 slow count", 12'h024, 32'h3);
        bus_wr(12'h024, 32'h55);
        rd_check("R11 slow write ignored", 12'h024, 32'h3);
        pulse(1'b1, 255);
        rd_check("R11 fast all ones", 12'h05C, 32'hFF);
        pulse(1'b1, 1);
        rd_check("R11 fast wrap", 12'h05C, 32'h0);
        bus_wr(12'h05C, 32'hAA);
        rd_check("R11 fast write ignored", 12'h05C, 32'h0);
        rd_check("R11 slow unaffected", 12'h024, 32'h3);
    endtask

    task automatic t_unmapped;
        rd_check("R12 unmapped read", 12'h010, 32'h0);
        rd_check("R12 unmapped read high", 12'hFFC, 32'h0);
        bus_wr(12'h08C, 32'hFFFF_FFFF);
        bus_wr(12'h00A, 32'hFFFF_FFFF);
        check("R12 led unchanged", {24'h0, led_out}, 32'h0);
        check("R12 flash unchanged", {31'h0, flash_wp_n}, 32'h0);
        rd_check("R12 vflag unchanged", 12'h030, 32'h0);
        rd_check("R12 pflag unchanged", 12'h038, 32'h0);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 32'h0);
        por_n = 1'b1;
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_ident();
        t_led();
        t_switch();
        t_card_flash();
        t_misc();
        t_vflags();
        t_pflags();
        t_reset_domains();
        t_counters();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule